// File: doc/BRIEF.md
# NAND Flash Command Launch Sequencer

This block runs one whole NAND flash operation from a single register write. Software first loads the address bytes, the transfer length and an optional second opcode. It then writes a control word whose top bit starts the operation. The sequencer drives the flash bus in order: first the opcode with the command latch high, then the requested number of address bytes with the address latch high. If the operation is a program, the write data follows. Next comes the optional second opcode, such as a program confirm, an erase confirm or a read start. The sequencer then waits for the device to report ready. For a read, the data is then pulled into the page buffer.

Each byte on the bus uses one write-enable or read-enable strobe. The low and high times of that strobe are parameters. The page buffer is held outside the block and is reached through a simple byte-addressed port: reads are combinational and writes use a single write-strobe. When the operation completes, the sequencer sets a command-done status bit. If data was moved, it also sets a transfer-done bit. Both bits are cleared by writing 1 to them, and they drive a level interrupt.

The register port uses a 3-bit word address: 0 control word, 1 second opcode, 2 length, 3 address bytes 0..3, 4 address bytes 4..7, 5 status.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the block is idle: both chip enables are high (`nf_ce_n`=2'b11), both strobes are high, and status (address 5) reads 0.
- R2: A write to address 0 with bit 31 set starts an operation. The opcode in bits 7:0 goes out first with CLE high. Bit 19 clear drives only `nf_ce_n[0]` low, bit 19 set drives only `nf_ce_n[1]` low, and that chip enable stays low for the whole operation.
- R3: When bit 30 is set, (bits 29:27)+1 address bytes follow with ALE high. They are taken from address 3 byte 0 upward and then continue into address 4. When bit 30 is clear, no address byte is sent, whatever bits 29:27 hold.
- R4: Bit 26 selects a read data phase and bit 25 selects a write data phase; if both are set, the read wins. The phase moves the number of bytes in address 2. A length of 0 gives no data phase. Write data is fetched from buffer addresses 0 to length-1 in order.
- R5: Address 1 with bit 8 set requests a second opcode, whose value is in bits 7:0. It is sent with CLE high after the write data, or after the address bytes when there is no write data. Bit 8 reads back 0 once the operation completes.
- R6: In a read data phase, the byte taken during the i-th read strobe is written to buffer address i.
- R7: After the last byte that is driven out, no read strobe occurs and the operation does not finish until at least T_WB cycles have passed and `nf_ready` is high.
- R8: Every strobe stays low for exactly T_LO cycles and stays high for at least T_HI cycles between pulses. WE# and RE# are never low at the same time, CLE and ALE are never high at the same time, and CLE, ALE and the driven byte stay stable while a strobe is low.
- R9: Status bit 31 (command done) is set at the end of every operation. Bit 28 (transfer done) is set only when a data phase ran. Bit 0 reads 1 while the block is busy. Writing 1 to bit 31 or to bit 28 clears only that bit. `irq` is the OR of bits 31 and 28.
- R10: While the block is busy, writes to addresses 0 through 4 are ignored: no new operation starts and no stored value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt, OR of the done bits |
| nf_ce_n | output | 2 | Active-low chip enables, die 0 and die 1 |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven to the flash |
| nf_dq_oe | output | 1 | Output enable for nf_dq_o |
| nf_dq_i | input | 8 | Byte returned by the flash |
| nf_ready | input | 1 | Ready/busy line, 1 = ready |
| buf_addr | output | LEN_W | Page buffer byte address |
| buf_we | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8 | Page buffer write data |
| buf_rdata | input | 8 | Page buffer read data |

## Verification
The hardest case to reach is a register write that arrives while a read is parked in the ready wait. In that window the bus is quiet and the block looks idle, yet it must still reject a new launch and any change to its length. The bench holds `nf_ready` low after starting a large-page read. During that stall it writes a new control word and a new length, and only then releases ready. Any stray byte on the bus, any early read strobe, or a changed length on readback then shows up as a mismatch against the expected byte queue.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_WDATA, PH_OP2, PH_WAIT, PH_RDATA, PH_DONE
  } phase_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       die1;
    logic [3:0] nadr;
    logic [7:0] opc;
  } launch_t;

  // Control word unpacking; read beats write when both are requested.
  function automatic launch_t decode_launch(input logic [31:0] w);
    launch_t l;
    l.rd   = w[26];
    l.wr   = w[25] & ~w[26];
    l.die1 = w[19];
    l.nadr = w[30] ? ({1'b0, w[29:27]} + 4'd1) : 4'd0;
    l.opc  = w[7:0];
    return l;
  endfunction

  // Phase order: CMD, ADDR, WDATA, OP2, WAIT, RDATA, DONE; empty phases skipped.
  function automatic phase_e next_phase(input phase_e cur, input logic has_adr,
                                        input logic has_w, input logic has_r,
                                        input logic has_op2);
    phase_e n;
    case (cur)
      PH_CMD:   n = has_adr ? PH_ADDR : has_w ? PH_WDATA : has_op2 ? PH_OP2 : PH_WAIT;
      PH_ADDR:  n = has_w ? PH_WDATA : has_op2 ? PH_OP2 : PH_WAIT;
      PH_WDATA: n = has_op2 ? PH_OP2 : PH_WAIT;
      PH_OP2:   n = PH_WAIT;
      PH_WAIT:  n = has_r ? PH_RDATA : PH_DONE;
      PH_RDATA: n = PH_DONE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [63:0] a, input logic [2:0] i);
    return a[{i, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/nfseq_regs.sv
module nfseq_regs #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             set_cmd_done,
  input  logic             set_xfer_done,
  input  logic             op2_consume,
  output logic             launch,
  output logic [31:0]      launch_word,
  output logic [8:0]       op2_q,
  output logic [LEN_W-1:0] len_q,
  output logic [63:0]      adr_q,
  output logic             irq
);
  localparam logic [2:0] A_CMD = 3'd0, A_OP2 = 3'd1, A_LEN = 3'd2,
                         A_ALO = 3'd3, A_AHI = 3'd4, A_STAT = 3'd5;

  logic cfg_we, cmd_done, xfer_done, stat_we;

  assign cfg_we      = reg_we && !busy;
  assign stat_we     = reg_we && (reg_addr == A_STAT);
  assign launch      = cfg_we && (reg_addr == A_CMD) && reg_wdata[31];
  assign launch_word = reg_wdata;
  assign irq         = cmd_done | xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op2_q <= '0;
      len_q <= '0;
      adr_q <= '0;
    end else if (cfg_we) begin
      case (reg_addr)
        A_OP2:   op2_q <= reg_wdata[8:0];
        A_LEN:   len_q <= reg_wdata[LEN_W-1:0];
        A_ALO:   adr_q[31:0] <= reg_wdata;
        A_AHI:   adr_q[63:32] <= reg_wdata;
        default: ;
      endcase
    end else if (op2_consume) begin
      op2_q[8] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done  <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      if (set_cmd_done)                     cmd_done  <= 1'b1;
      else if (stat_we && reg_wdata[31])    cmd_done  <= 1'b0;
      if (set_xfer_done)                    xfer_done <= 1'b1;
      else if (stat_we && reg_wdata[28])    xfer_done <= 1'b0;
    end
  end

  always_comb begin
    case (reg_raddr)
      A_OP2:   reg_rdata = {23'd0, op2_q};
      A_LEN:   reg_rdata = 32'(len_q);
      A_ALO:   reg_rdata = adr_q[31:0];
      A_AHI:   reg_rdata = adr_q[63:32];
      A_STAT:  reg_rdata = {cmd_done, 2'b00, xfer_done, 27'd0, busy};
      default: reg_rdata = '0;
    endcase
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && (reg_addr == A_LEN) |=> $stable(len_q));
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we && reg_wdata[31] && !set_cmd_done |=> !cmd_done);

endmodule

// File: rtl/nfseq_strobe.sv
module nfseq_strobe #(
  parameter int T_LO = 2,
  parameter int T_HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic low,
  output logic sample,
  output logic fin
);
  localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  assign sample = active && low && (cnt == CW'(T_LO - 1));
  assign fin    = active && !low && (cnt == CW'(T_HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      low    <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        low    <= 1'b1;
        cnt    <= '0;
      end
    end else if (low) begin
      if (sample) begin
        low <= 1'b0;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end else begin
      if (fin) active <= 1'b0;
      else     cnt    <= cnt + 1'b1;
    end
  end

  p_low_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active && low && !sample |=> active && low);
  p_high_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low) |-> active);

endmodule

// File: rtl/nfseq_seq.sv
module nfseq_seq
  import nfseq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int T_WB  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [31:0]      launch_word,
  input  logic [8:0]       op2_q,
  input  logic [LEN_W-1:0] len_q,
  input  logic [63:0]      adr_q,
  input  logic             st_active,
  input  logic             st_low,
  input  logic             st_sample,
  input  logic             st_fin,
  output logic             st_start,
  output logic             busy,
  output logic             set_cmd_done,
  output logic             set_xfer_done,
  output logic             op2_consume,
  output logic [1:0]       nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_ready,
  output logic [LEN_W-1:0] buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata
);
  localparam int WBW = $clog2(T_WB + 1);

  phase_e           phase, nxt;
  launch_t          cur;
  logic [LEN_W-1:0] idx;
  logic [WBW-1:0]   wb_cnt;
  logic             pend, last, drive_ph, byte_ph, byte_done;

  assign drive_ph = (phase == PH_CMD) || (phase == PH_ADDR) ||
                    (phase == PH_WDATA) || (phase == PH_OP2);
  assign byte_ph  = drive_ph || (phase == PH_RDATA);
  assign nxt      = next_phase(phase, cur.nadr != 4'd0, cur.wr && (len_q != '0),
                               cur.rd && (len_q != '0), op2_q[8]);

  always_comb begin
    case (phase)
      PH_ADDR:           last = (idx == LEN_W'(cur.nadr - 4'd1));
      PH_WDATA, PH_RDATA: last = (idx == len_q - LEN_W'(1));
      default:           last = 1'b1;
    endcase
  end

  assign st_start      = byte_ph && !pend && !st_active;
  assign byte_done     = pend && st_fin;
  assign busy          = (phase != PH_IDLE);
  assign set_cmd_done  = (phase == PH_DONE);
  assign op2_consume   = (phase == PH_DONE);
  assign set_xfer_done = byte_done && last && ((phase == PH_WDATA) || (phase == PH_RDATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cur    <= '0;
      idx    <= '0;
      pend   <= 1'b0;
      wb_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (launch) begin
          cur   <= decode_launch(launch_word);
          phase <= PH_CMD;
          idx   <= '0;
          pend  <= 1'b0;
        end
        PH_WAIT: begin
          if (wb_cnt < WBW'(T_WB - 1)) wb_cnt <= wb_cnt + 1'b1;
          else if (nf_ready)           phase  <= nxt;
        end
        PH_DONE: phase <= PH_IDLE;
        default: begin
          if (st_start) pend <= 1'b1;
          if (byte_done) begin
            pend <= 1'b0;
            if (last) begin
              phase <= nxt;
              idx   <= '0;
            end else idx <= idx + 1'b1;
          end
        end
      endcase
      if (phase != PH_WAIT) wb_cnt <= '0;
    end
  end

  // Bus drive
  assign nf_ce_n   = !busy ? 2'b11 : (cur.die1 ? 2'b01 : 2'b10);
  assign nf_cle    = (phase == PH_CMD) || (phase == PH_OP2);
  assign nf_ale    = (phase == PH_ADDR);
  assign nf_dq_oe  = drive_ph;
  assign nf_we_n   = !(st_active && st_low && drive_ph);
  assign nf_re_n   = !(st_active && st_low && (phase == PH_RDATA));
  assign buf_addr  = idx;
  assign buf_we    = pend && st_sample && (phase == PH_RDATA);
  assign buf_wdata = nf_dq_i;

  always_comb begin
    case (phase)
      PH_CMD:   nf_dq_o = cur.opc;
      PH_ADDR:  nf_dq_o = addr_byte(adr_q, idx[2:0]);
      PH_WDATA: nf_dq_o = buf_rdata;
      PH_OP2:   nf_dq_o = op2_q[7:0];
      default:  nf_dq_o = 8'h00;
    endcase
  end

  p_wait_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_WAIT) && (phase != PH_WAIT) |-> $past(nf_ready));
  p_lines_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n && $past(!nf_we_n) |-> $stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_o));
  p_one_die_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nf_ce_n));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_cmd_done |=> !busy);
  p_no_relaunch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (phase != PH_DONE) |=> busy);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nfseq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int T_LO  = 2,
  parameter int T_HI  = 2,
  parameter int T_WB  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic [1:0]       nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_ready,
  output logic [LEN_W-1:0] buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata
);
  logic             busy, set_cmd_done, set_xfer_done, op2_consume, launch;
  logic [31:0]      launch_word;
  logic [8:0]       op2_q;
  logic [LEN_W-1:0] len_q;
  logic [63:0]      adr_q;
  logic             st_start, st_active, st_low, st_sample, st_fin;

  nfseq_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(busy), .set_cmd_done(set_cmd_done), .set_xfer_done(set_xfer_done),
    .op2_consume(op2_consume), .launch(launch), .launch_word(launch_word),
    .op2_q(op2_q), .len_q(len_q), .adr_q(adr_q), .irq(irq));

  nfseq_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(st_start), .active(st_active),
    .low(st_low), .sample(st_sample), .fin(st_fin));

  nfseq_seq #(.LEN_W(LEN_W), .T_WB(T_WB)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_word(launch_word),
    .op2_q(op2_q), .len_q(len_q), .adr_q(adr_q),
    .st_active(st_active), .st_low(st_low), .st_sample(st_sample), .st_fin(st_fin),
    .st_start(st_start), .busy(busy), .set_cmd_done(set_cmd_done),
    .set_xfer_done(set_xfer_done), .op2_consume(op2_consume),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i),
    .nf_ready(nf_ready), .buf_addr(buf_addr), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata));

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_cmd_done) || $past(set_xfer_done));

endmodule

// File: tb/nand_cmd_seq_tb.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb;
  localparam int LEN_W = 12, T_LO = 2, T_HI = 2, T_WB = 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0, reg_raddr = 5;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, buf_we;
  logic [1:0] nf_ce_n;
  logic [7:0] nf_dq_o, nf_dq_i, buf_wdata, buf_rdata;
  logic nf_ready = 1;
  logic [LEN_W-1:0] buf_addr;

  always #2.5 clk = ~clk;

  nand_cmd_seq #(.LEN_W(LEN_W), .T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i),
    .nf_ready(nf_ready), .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata));

  int tests = 0, fails = 0;
  logic [7:0] bmem [64];
  logic [7:0] cap  [64];
  int cap_n = 0;
  logic [9:0] exp_q [$];
  logic [1:0] exp_ce = 2'b11;
  int re_pulses = 0, pulses = 0;
  int cyc = 0, we_run = 0, re_run = 0, gap = 0, last_we_rise = 0;
  logic prev_we = 1, prev_re = 1;
  logic [9:0] lat_b;

  assign buf_rdata = bmem[buf_addr[5:0]];
  assign nf_dq_i   = 8'hA0 + 8'(re_pulses);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Per-cycle reference monitor of the flash bus
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!nf_we_n && !nf_re_n) chk(0, "R8", "both strobes low", 1, 0);
    if (nf_cle && nf_ale)     chk(0, "R8", "CLE and ALE high", 1, 0);
    if (buf_we) begin cap[buf_addr[5:0]] = buf_wdata; cap_n++; end
    if (!nf_we_n) begin
      if (prev_we) begin
        if (pulses > 0) chk(gap >= T_HI, "R8", "we high gap", gap, T_HI);
        chk(nf_ce_n == exp_ce, "R2", "chip enable", nf_ce_n, exp_ce);
      end
      we_run++;
      lat_b = {nf_cle, nf_ale, nf_dq_o};
    end else if (!prev_we) begin
      chk(we_run == T_LO, "R8", "we low width", we_run, T_LO);
      if (exp_q.size() == 0) chk(0, "R10", "unexpected bus byte", lat_b, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(lat_b == e, "R3", "bus byte {cle,ale,dq}", lat_b, e);
      end
      we_run = 0; gap = 1; pulses++; last_we_rise = cyc;
    end else if (nf_re_n) gap++;
    if (!nf_re_n) begin
      if (prev_re) begin
        if (re_pulses == 0) chk(cyc - last_we_rise >= T_WB, "R7", "tWB before read", cyc - last_we_rise, T_WB);
        else chk(gap >= T_HI, "R8", "re high gap", gap, T_HI);
        chk(nf_ce_n == exp_ce, "R2", "chip enable on read", nf_ce_n, exp_ce);
      end
      re_run++;
    end else if (!prev_re) begin
      chk(re_run == T_LO, "R8", "re low width", re_run, T_LO);
      re_run = 0; gap = 1; re_pulses++;
    end
    prev_we = nf_we_n; prev_re = nf_re_n;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a; #0.5; d = reg_rdata;
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] v);
    exp_q.push_back({k, v});
  endtask

  task automatic new_op(input logic [1:0] ce);
    exp_ce = ce; re_pulses = 0; pulses = 0; cap_n = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); rd(5, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clr();
    wr(5, 32'h9000_0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 64; i++) bmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(5, s);
    chk(s == 0, "R1", "status after reset", s, 0);
    chk(nf_ce_n == 2'b11, "R1", "ce after reset", nf_ce_n, 3);
    chk(nf_we_n && nf_re_n, "R1", "strobes after reset", {nf_we_n, nf_re_n}, 3);

    // Erase with confirm, 3 address bytes
    wr(1, 32'h1D0); wr(3, 32'h0033_2211);
    new_op(2'b10);
    push(2'b10, 8'h60); push(2'b01, 8'h11); push(2'b01, 8'h22); push(2'b01, 8'h33);
    push(2'b10, 8'hD0);
    wr(0, 32'hD000_0060); wait_idle();
    chk(exp_q.size() == 0, "R5", "erase bytes all seen", exp_q.size(), 0);
    rd(5, s); chk(s == 32'h8000_0000, "R9", "erase status", s, 32'h8000_0000);
    chk(irq == 1, "R9", "irq high", irq, 1);
    rd(1, s); chk(s[8] == 0, "R5", "second opcode consumed", s[8], 0);
    wr(5, 32'h8000_0000); rd(5, s);
    chk(s == 0 && irq == 0, "R9", "w1c cmd done", s, 0);

    // Program on die 1, 5 address bytes, 8 data bytes
    wr(2, 8); wr(3, 32'h4433_2211); wr(4, 32'h0000_0077); wr(1, 32'h110);
    new_op(2'b01);
    push(2'b10, 8'h80);
    push(2'b01, 8'h11); push(2'b01, 8'h22); push(2'b01, 8'h33); push(2'b01, 8'h44); push(2'b01, 8'h77);
    for (int i = 0; i < 8; i++) push(2'b00, bmem[i]);
    push(2'b10, 8'h10);
    wr(0, 32'hE208_0080); wait_idle();
    chk(exp_q.size() == 0, "R4", "program bytes all seen", exp_q.size(), 0);
    rd(5, s); chk(s == 32'h9000_0000, "R9", "program status", s, 32'h9000_0000);
    wr(5, 32'h1000_0000); rd(5, s);
    chk(s == 32'h8000_0000, "R9", "w1c xfer only", s, 32'h8000_0000);
    clr();

    // Large-page read held busy; writes during the stall
    wr(2, 6); wr(1, 32'h130); nf_ready = 0;
    new_op(2'b10);
    push(2'b10, 8'h00);
    push(2'b01, 8'h11); push(2'b01, 8'h22); push(2'b01, 8'h33); push(2'b01, 8'h44); push(2'b01, 8'h77);
    push(2'b10, 8'h30);
    wr(0, 32'hE400_0000);
    repeat (40) @(negedge clk);
    wr(0, 32'hD000_0060); wr(2, 33);
    repeat (20) @(negedge clk);
    rd(5, s); chk(s[0] == 1, "R7", "busy while not ready", s[0], 1);
    chk(re_pulses == 0, "R7", "no read strobe before ready", re_pulses, 0);
    nf_ready = 1; wait_idle();
    chk(exp_q.size() == 0, "R10", "no extra bytes after ignored launch", exp_q.size(), 0);
    rd(2, s); chk(s == 6, "R10", "length kept while busy", s, 6);
    chk(cap_n == 6, "R6", "read byte count", cap_n, 6);
    for (int i = 0; i < 6; i++) chk(cap[i] == 8'(8'hA0 + i), "R6", "read data", cap[i], 8'hA0 + i);
    rd(5, s); chk(s == 32'h9000_0000, "R9", "read status", s, 32'h9000_0000);
    clr();

    // ID read: one address byte, 5 data bytes, die 0
    wr(2, 5); wr(3, 0);
    new_op(2'b10);
    push(2'b10, 8'h90); push(2'b01, 8'h00);
    wr(0, 32'hC400_0090); wait_idle();
    chk(exp_q.size() == 0, "R2", "id bytes seen", exp_q.size(), 0);
    chk(cap_n == 5, "R4", "id length", cap_n, 5);
    chk(cap[4] == 8'hA4, "R6", "id last byte", cap[4], 8'hA4);
    clr();

    // Bit 30 clear: count field ignored
    new_op(2'b10);
    push(2'b10, 8'hFF);
    wr(0, 32'hB800_00FF); wait_idle();
    chk(exp_q.size() == 0, "R3", "no address bytes", exp_q.size(), 0);
    rd(5, s); chk(s == 32'h8000_0000, "R9", "no xfer bit", s, 32'h8000_0000);
    clr();

    // Zero length read: no data phase
    wr(2, 0);
    new_op(2'b10);
    push(2'b10, 8'h70); push(2'b01, 8'h00);
    wr(0, 32'hC400_0070); wait_idle();
    chk(re_pulses == 0 && cap_n == 0, "R4", "zero length no reads", re_pulses, 0);
    rd(5, s); chk(s == 32'h8000_0000, "R4", "zero length status", s, 32'h8000_0000);
    clr();

    // Both direction bits: read wins
    wr(2, 2);
    new_op(2'b10);
    push(2'b10, 8'h05);
    wr(0, 32'h8600_0005); wait_idle();
    chk(exp_q.size() == 0 && cap_n == 2, "R4", "read wins over write", cap_n, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule